// File: doc/BRIEF.md
# Five-Layer Priority and Blend Compositor

This block merges the pixels of one scan position into a single output pixel. Each cycle it receives one RGB565 pixel from each of four background planes and one from the sprite plane. Each pixel comes with a valid flag. Each plane also has a priority value. The block finds the frontmost opaque pixel, called the winner. It also finds the next opaque pixel behind it, called the runner-up. If no plane is opaque behind the winner, the backdrop colour stands in as the runner-up.

The block then either passes the winner through or combines winner and runner-up. The combination is a per-channel saturating add or a clamped subtract, applied separately to each colour channel. The result is registered once per pixel clock toward scan-out. The sprite plane is ranked by its own priority value, exactly like a background plane. Software can therefore place sprites in front of, between or behind the backgrounds.

A per-plane enable mask limits blending to chosen winners. For example, a translucent overlay plane can brighten or darken whatever lies behind it, while all other planes stay opaque.

Top module: `layer_mixer`

## Requirements
- R1: While `rst_n` is low, `out_pix` is 16'h0000.
- R2: A plane is opaque only when its valid flag is 1 and its pixel is not 16'h0000; a transparent plane is never shown or blended, whatever its priority.
- R3: When no plane is opaque, the next `out_pix` equals `backdrop`, in every blend mode.
- R4: Among opaque planes, the one with the numerically largest priority value is the winner and is shown when blending is off (`blend_mode` = 2'b00).
- R5: When opaque planes share the largest priority, the plane with the lower index wins; backgrounds are indices 0 to 3 (plane n at `bg_pix[16n+15:16n]`) and the sprite is index 4.
- R6: The sprite plane is ranked by `spr_prio` on the same scale as the backgrounds, so it may appear in front of or behind any background.
- R7: With `blend_mode` = 2'b01 and the winner's bit set in `blend_mask`, each channel of the output is winner plus runner-up, saturated at the channel maximum. The channels are red [15:11], green [10:5] and blue [4:0]. The runner-up is the next opaque plane in the same ranking, or `backdrop` if there is none.
- R8: With `blend_mode` = 2'b10 and the winner's mask bit set, each channel is winner minus runner-up, clamped at zero.
- R9: With `blend_mode` = 2'b11 and the winner's mask bit set, each channel is runner-up minus winner, clamped at zero.
- R10: When the winner's bit in `blend_mask` (bit index = plane index) is clear, the winner is output unchanged in any blend mode.
- R11: `out_pix` changes only at a rising clock edge and reflects the inputs sampled at that edge, one register after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bg_pix | input | NUM_BG*16 | Background pixels, plane n in bits [16n+15:16n] |
| bg_vld | input | NUM_BG | Valid flag per background plane |
| bg_prio | input | NUM_BG*PRIO_W | Priority per background plane, larger is nearer |
| spr_pix | input | 16 | Sprite pixel |
| spr_vld | input | 1 | Sprite pixel valid |
| spr_prio | input | PRIO_W | Sprite priority on the background scale |
| backdrop | input | 16 | Colour shown where nothing is opaque |
| blend_mode | input | 2 | 00 off, 01 add, 10 subtract, 11 reverse subtract |
| blend_mask | input | NUM_BG+1 | Per-plane blend enable, bit 4 is the sprite |
| out_pix | output | 16 | Registered composited pixel |

## Verification
Every result of this block lands exactly one rising edge after the inputs that produce it. The bench therefore changes stimulus on a falling edge and lets one rising edge pass. It compares `out_pix` at the following falling edge, before it applies anything new. Once per run, the bench also reads the output a moment after new inputs are applied, but before the next rising edge. At that point it expects the previous result, which shows that nothing reaches `out_pix` combinationally. The bound assertions use the same one-cycle offset: they compare against the inputs of the previous cycle.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
   localparam int R_W   = 5;
   localparam int G_W   = 6;
   localparam int B_W   = 5;
   localparam int PIX_W = R_W + G_W + B_W;

   typedef logic [PIX_W-1:0] pix_t;

   typedef enum logic [1:0] {
      BL_OFF  = 2'b00,
      BL_ADD  = 2'b01,
      BL_SUB  = 2'b10,
      BL_RSUB = 2'b11
   } blend_e;
endpackage

// File: rtl/mixer_opaque.sv
module mixer_opaque
   import mixer_pkg::*;
#(
   parameter int NUM_L = 5
) (
   input  logic [NUM_L*PIX_W-1:0] pix_flat,
   input  logic [NUM_L-1:0]       vld,
   output logic [NUM_L-1:0]       opq
);
   for (genvar li = 0; li < NUM_L; li++) begin : g_layer
      assign opq[li] = vld[li] && (pix_flat[li*PIX_W +: PIX_W] != '0);
   end
endmodule

// File: rtl/mixer_rank.sv
module mixer_rank #(
   parameter int NUM_L  = 5,
   parameter int PRIO_W = 2,
   parameter int IDX_W  = 3
) (
   input  logic [NUM_L-1:0]        opq,
   input  logic [NUM_L*PRIO_W-1:0] prio_flat,
   output logic                    top_hit,
   output logic [IDX_W-1:0]        top_idx,
   output logic                    sec_hit,
   output logic [IDX_W-1:0]        sec_idx
);
   logic [PRIO_W-1:0] top_best;
   logic [PRIO_W-1:0] sec_best;

   // strict compare keeps the lowest index on equal priority
   always_comb begin
      top_hit  = 1'b0;
      top_idx  = '0;
      top_best = '0;
      for (int i = 0; i < NUM_L; i++) begin
         if (opq[i] && (!top_hit || prio_flat[i*PRIO_W +: PRIO_W] > top_best)) begin
            top_hit  = 1'b1;
            top_idx  = IDX_W'(i);
            top_best = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

   always_comb begin
      sec_hit  = 1'b0;
      sec_idx  = '0;
      sec_best = '0;
      for (int i = 0; i < NUM_L; i++) begin
         if (opq[i] && (IDX_W'(i) != top_idx) &&
             (!sec_hit || prio_flat[i*PRIO_W +: PRIO_W] > sec_best)) begin
            sec_hit  = 1'b1;
            sec_idx  = IDX_W'(i);
            sec_best = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/mixer_chan.sv
module mixer_chan
   import mixer_pkg::*;
#(
   parameter int W = 5
) (
   input  blend_e       op,
   input  logic [W-1:0] fg,
   input  logic [W-1:0] bk,
   output logic [W-1:0] res
);
   logic [W:0] sum;
   logic [W:0] d_fb;
   logic [W:0] d_bf;

   assign sum  = {1'b0, fg} + {1'b0, bk};
   assign d_fb = {1'b0, fg} - {1'b0, bk};
   assign d_bf = {1'b0, bk} - {1'b0, fg};

   always_comb begin
      unique case (op)
         BL_ADD:  res = sum[W]  ? '1 : sum[W-1:0];
         BL_SUB:  res = d_fb[W] ? '0 : d_fb[W-1:0];
         BL_RSUB: res = d_bf[W] ? '0 : d_bf[W-1:0];
         default: res = fg;
      endcase
   end
endmodule

// File: rtl/layer_mixer.sv
module layer_mixer
   import mixer_pkg::*;
#(
   parameter int NUM_BG = 4,
   parameter int PRIO_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_BG*16-1:0]     bg_pix,
   input  logic [NUM_BG-1:0]        bg_vld,
   input  logic [NUM_BG*PRIO_W-1:0] bg_prio,
   input  logic [15:0]              spr_pix,
   input  logic                     spr_vld,
   input  logic [PRIO_W-1:0]        spr_prio,
   input  logic [15:0]              backdrop,
   input  logic [1:0]               blend_mode,
   input  logic [NUM_BG:0]          blend_mask,
   output logic [15:0]              out_pix
);
   localparam int NUM_L = NUM_BG + 1;
   localparam int IDX_W = $clog2(NUM_L);

   if (NUM_BG < 1) begin : g_bad_bg
      $error("layer_mixer: NUM_BG must be at least 1");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("layer_mixer: PRIO_W must be at least 1");
   end
   if (PIX_W != 16) begin : g_bad_pix
      $error("layer_mixer: channel widths must total 16 bits");
   end

   logic [NUM_L*PIX_W-1:0]  all_pix;
   logic [NUM_L-1:0]        all_vld;
   logic [NUM_L*PRIO_W-1:0] all_prio;
   logic [NUM_L-1:0]        opq;
   logic                    top_hit, sec_hit;
   logic [IDX_W-1:0]        top_idx, sec_idx;
   pix_t                    fg_px, bk_px, mix_px, nxt_px;
   blend_e                  mode;

   assign all_pix  = {spr_pix, bg_pix};
   assign all_vld  = {spr_vld, bg_vld};
   assign all_prio = {spr_prio, bg_prio};
   assign mode     = blend_e'(blend_mode);

   mixer_opaque #(.NUM_L(NUM_L)) u_opq (
      .pix_flat (all_pix),
      .vld      (all_vld),
      .opq      (opq)
   );

   mixer_rank #(.NUM_L(NUM_L), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
      .opq       (opq),
      .prio_flat (all_prio),
      .top_hit   (top_hit),
      .top_idx   (top_idx),
      .sec_hit   (sec_hit),
      .sec_idx   (sec_idx)
   );

   assign fg_px = all_pix[top_idx*PIX_W +: PIX_W];
   assign bk_px = sec_hit ? all_pix[sec_idx*PIX_W +: PIX_W] : backdrop;

   for (genvar ci = 0; ci < 3; ci++) begin : g_chan
      localparam int CW = (ci == 0) ? B_W : (ci == 1) ? G_W : R_W;
      localparam int LO = (ci == 0) ? 0   : (ci == 1) ? B_W : B_W + G_W;
      mixer_chan #(.W(CW)) u_chan (
         .op  (mode),
         .fg  (fg_px[LO +: CW]),
         .bk  (bk_px[LO +: CW]),
         .res (mix_px[LO +: CW])
      );
   end

   always_comb begin
      if (!top_hit)
         nxt_px = backdrop;
      else if (mode != BL_OFF && blend_mask[top_idx])
         nxt_px = mix_px;
      else
         nxt_px = fg_px;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_pix <= '0;
      else        out_pix <= nxt_px;
   end
endmodule

// File: rtl/layer_mixer_chk.sv
module layer_mixer_chk #(
   parameter int NUM_BG = 4,
   parameter int PRIO_W = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_BG*16-1:0]     bg_pix,
   input logic [NUM_BG-1:0]        bg_vld,
   input logic [15:0]              spr_pix,
   input logic                     spr_vld,
   input logic [15:0]              backdrop,
   input logic [1:0]               blend_mode,
   input logic [NUM_BG:0]          blend_mask,
   input logic [15:0]              out_pix
);
   localparam int NUM_L = NUM_BG + 1;

   logic [NUM_L*16-1:0] px;
   logic [NUM_L-1:0]    vis;
   logic [15:0]         merged;
   logic                all_max;
   logic                all_same;

   assign px = {spr_pix, bg_pix};

   always_comb begin
      merged   = '0;
      all_max  = 1'b1;
      all_same = 1'b1;
      for (int i = 0; i < NUM_L; i++) begin
         vis[i] = (i == NUM_BG ? spr_vld : bg_vld[i]) && (px[i*16 +: 16] != 16'h0);
         if (vis[i]) merged = merged | px[i*16 +: 16];
      end
      for (int i = 0; i < NUM_L; i++) begin
         if (vis[i] && px[i*16 +: 16] != 16'hFFFF) all_max = 1'b0;
         if (vis[i] && px[i*16 +: 16] != merged)  all_same = 1'b0;
      end
   end

   assert_backdrop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vis == '0) |=> (out_pix == $past(backdrop)));

   assert_lone_layer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (blend_mode == 2'b00 && $countones(vis) == 1) |=> (out_pix == $past(merged)));

   assert_add_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (blend_mode == 2'b01 && vis != '0 && all_max && (&blend_mask)) |=> (out_pix == 16'hFFFF));

   assert_sub_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blend_mode == 2'b10 && $countones(vis) >= 2 && all_same && (&blend_mask))
      |=> (out_pix == 16'h0000));

   assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(vis) == 1 && (blend_mask & vis) == '0) |=> (out_pix == $past(merged)));
endmodule

bind layer_mixer layer_mixer_chk #(.NUM_BG(NUM_BG), .PRIO_W(PRIO_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bg_pix     (bg_pix),
   .bg_vld     (bg_vld),
   .spr_pix    (spr_pix),
   .spr_vld    (spr_vld),
   .backdrop   (backdrop),
   .blend_mode (blend_mode),
   .blend_mask (blend_mask),
   .out_pix    (out_pix)
);

// File: tb/layer_mixer_test.sv
module layer_mixer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] s_pix  [5];
   logic        s_vld  [5];
   logic [1:0]  s_prio [5];
   logic [15:0] s_bd;
   logic [1:0]  s_mode;
   logic [4:0]  s_mask;
   logic [15:0] out_pix;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   layer_mixer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bg_pix     ({s_pix[3], s_pix[2], s_pix[1], s_pix[0]}),
      .bg_vld     ({s_vld[3], s_vld[2], s_vld[1], s_vld[0]}),
      .bg_prio    ({s_prio[3], s_prio[2], s_prio[1], s_prio[0]}),
      .spr_pix    (s_pix[4]),
      .spr_vld    (s_vld[4]),
      .spr_prio   (s_prio[4]),
      .backdrop   (s_bd),
      .blend_mode (s_mode),
      .blend_mask (s_mask),
      .out_pix    (out_pix)
   );

   function automatic int chan(int a, int b, int mx);
      int r;
      case (s_mode)
         2'b01:   r = (a + b > mx) ? mx : a + b;
         2'b10:   r = (a < b) ? 0 : a - b;
         2'b11:   r = (b < a) ? 0 : b - a;
         default: r = a;
      endcase
      return r;
   endfunction

   function automatic logic [15:0] model();
      int top = -1;
      int sec = -1;
      logic [15:0] a, b;
      int r, g, bl;
      for (int i = 0; i < 5; i++)
         if (s_vld[i] && s_pix[i] != 0 && (top < 0 || s_prio[i] > s_prio[top])) top = i;
      for (int i = 0; i < 5; i++)
         if (i != top && s_vld[i] && s_pix[i] != 0 && (sec < 0 || s_prio[i] > s_prio[sec])) sec = i;
      if (top < 0) return s_bd;
      a = s_pix[top];
      b = (sec < 0) ? s_bd : s_pix[sec];
      if (s_mode == 2'b00 || !s_mask[top]) return a;
      r  = chan(int'(a[15:11]), int'(b[15:11]), 31);
      g  = chan(int'(a[10:5]),  int'(b[10:5]),  63);
      bl = chan(int'(a[4:0]),   int'(b[4:0]),   31);
      return 16'((r << 11) | (g << 5) | bl);
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      for (int i = 0; i < 5; i++) begin
         s_pix[i] = 16'h0; s_vld[i] = 1'b0; s_prio[i] = 2'd0;
      end
      s_bd = 16'h0; s_mode = 2'b00; s_mask = 5'b0;
   endtask

   // stimulus already set after a falling edge; result due one rising edge later
   task automatic step(string req);
      logic [15:0] exp;
      exp = model();
      @(posedge clk);
      @(negedge clk);
      chk(req, out_pix, exp);
   endtask

   task automatic opaque(int i, logic [15:0] p, logic [1:0] pr);
      s_pix[i] = p; s_vld[i] = 1'b1; s_prio[i] = pr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      logic [15:0] prev;
      seed = $urandom(32'd2024);
      clear_all();
      opaque(0, 16'h1234, 2'd3);
      s_bd = 16'hABCD;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", out_pix, 16'h0000);
      rst_n = 1'b1;

      // R3 nothing valid
      clear_all(); s_bd = 16'h5A5A;
      s_pix[1] = 16'h7777;
      step("R3");
      // R2 valid but zero pixels, and invalid nonzero pixel at high prio
      for (int i = 0; i < 5; i++) begin s_vld[i] = 1'b1; s_pix[i] = 16'h0; s_prio[i] = 2'd3; end
      step("R2");
      clear_all(); s_bd = 16'h0101;
      s_pix[2] = 16'hFFFF; s_vld[2] = 1'b0; s_prio[2] = 2'd3;
      opaque(1, 16'h4321, 2'd0);
      step("R2");
      chk("R2", out_pix, 16'h4321);
      // R4 largest priority
      clear_all();
      opaque(0, 16'h1111, 2'd1); opaque(1, 16'h2222, 2'd2);
      opaque(2, 16'h3333, 2'd2); opaque(3, 16'h4444, 2'd3);
      step("R4");
      chk("R4", out_pix, 16'h4444);
      // R5 tie
      s_prio[3] = 2'd1;
      step("R5");
      chk("R5", out_pix, 16'h2222);
      // R6 sprite in front, then behind
      opaque(4, 16'h5555, 2'd3);
      step("R6");
      chk("R6", out_pix, 16'h5555);
      s_prio[4] = 2'd2;
      step("R5");
      chk("R5", out_pix, 16'h2222);
      s_prio[4] = 2'd0;
      step("R6");
      // R7 saturating add
      clear_all(); s_mask = 5'b11111; s_mode = 2'b01;
      opaque(0, 16'hF81F, 2'd2); opaque(1, 16'h0821, 2'd1);
      step("R7");
      chk("R7", out_pix, 16'hF83F);
      // R7 lone plane blends with backdrop
      s_vld[1] = 1'b0; s_bd = 16'h0842;
      step("R7");
      // R8 subtract with clamp
      s_vld[1] = 1'b1; s_mode = 2'b10;
      s_pix[0] = 16'h8410; s_pix[1] = 16'h4A1F;
      step("R8");
      // R9 reverse subtract
      s_mode = 2'b11;
      step("R9");
      // R10 mask clear on winner
      s_mask = 5'b11110; s_mode = 2'b01;
      step("R10");
      chk("R10", out_pix, 16'h8410);
      // R11 no combinational path: output holds until the edge
      prev = out_pix;
      s_pix[0] = 16'h0F0F; s_mask = 5'b0;
      #1;
      chk("R11", out_pix, prev);
      step("R11");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         for (int i = 0; i < 5; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            s_pix[i]  = (sel < 2) ? 16'h0 : (sel == 2) ? 16'hFFFF : 16'($urandom);
            s_vld[i]  = ($urandom_range(0, 9) != 0);
            s_prio[i] = 2'($urandom);
         end
         s_bd   = 16'($urandom);
         s_mode = 2'($urandom);
         s_mask = 5'($urandom);
         case (s_mode)
            2'b01:   step("R7");
            2'b10:   step("R8");
            2'b11:   step("R9");
            default: step("R4");
         endcase
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule